// File: doc/BRIEF.md
# Fetch Target Alignment Trap Unit

This block sits where a small core resolves control transfers. For each jump, register-indirect jump, conditional branch or trap return, it works out the target and checks it against the instruction alignment that is in force. It then either issues a redirect to that target or raises an instruction-address-misaligned exception. When it raises the exception, it redirects to a fixed trap vector, withholds the link-register write and reports the faulting PC and the target that caused the fault.

The required alignment changes at run time. A one-bit state holds the compressed-instruction enable, and this bit resets to enabled. When the bit is set, 2-byte alignment is enough. When it is clear, targets must be 4-byte aligned. Software writes the bit through a dedicated operation. A request to clear it is dropped when the instruction after the write would not be 4-byte aligned. On a trap return, the saved exception PC, given on `base_i`, is masked to the alignment currently in force.

Every result is registered. An operation presented on a clock edge shows its results on the outputs during the following cycle, and each trap pulse lasts exactly one cycle.

Top module: `fetch_align_trap`

## Requirements
- R1: For a register-indirect jump (`op_i`=2), the target is `base_i + offset_i` with bit 0 cleared. An odd sum by itself never causes a trap.
- R2: While the compressed bit is set, a jump, register-indirect jump or taken branch whose target has bit 1 set and bit 0 clear redirects to that target (`redir_valid_o`=1, `redir_pc_o`=target) and raises no trap. Direct jumps (`op_i`=1) and branches (`op_i`=3) target `pc_i + offset_i`.
- R3: While the compressed bit is clear, a jump, register-indirect jump or taken branch whose target has bit 1 set raises a trap. In any mode, a direct jump or taken branch whose target has bit 0 set also raises a trap.
- R4: A branch with `taken_i`=0 never traps and never redirects, whatever its target.
- R5: A trapping jump does not write the link register (`link_we_o`=0). A jump that does not trap writes `pc_i+4` to `rd_i`, except that `rd_i`=0 never produces a write.
- R6: On a trap, `trap_epc_o` equals `pc_i` of the faulting instruction, `trap_tval_o` equals the misaligned target, and `trap_cause_o` is 0.
- R7: On a trap, `redir_valid_o`=1 and `redir_pc_o` equals the parameter `TVEC` instead of the computed target.
- R8: A compressed-bit write (`op_i`=4) with `cwr_val_i`=1 always sets the bit. With `cwr_val_i`=0, it clears the bit only when `(pc_i+4)` has bit 1 clear; otherwise the bit keeps its value. The bit is visible on `c_en_o`.
- R9: A trap return (`op_i`=5) redirects to `base_i` with bit 0 cleared. Bit 1 is also cleared when the compressed bit is clear. A trap return never traps.
- R10: After reset `c_en_o`=1 and all valid and write-enable outputs are 0. `trap_valid_o` is high for exactly one cycle per faulting operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | 0 none, 1 jump, 2 register-indirect jump, 3 branch, 4 compressed-bit write, 5 trap return |
| taken_i | input | 1 | Branch condition outcome |
| base_i | input | XLEN | Base register value, or saved exception PC for a trap return |
| offset_i | input | XLEN | Signed offset |
| pc_i | input | XLEN | Address of the operation |
| rd_i | input | 5 | Link destination index |
| cwr_val_i | input | 1 | Value written to the compressed bit |
| redir_valid_o | output | 1 | Redirect request |
| redir_pc_o | output | XLEN | Redirect address |
| link_we_o | output | 1 | Link register write enable |
| link_rd_o | output | 5 | Link register index |
| link_data_o | output | XLEN | Link value |
| trap_valid_o | output | 1 | Misaligned-fetch exception pulse |
| trap_cause_o | output | 4 | Exception cause code |
| trap_epc_o | output | XLEN | Faulting instruction address |
| trap_tval_o | output | XLEN | Faulting target address |
| c_en_o | output | 1 | Current compressed-instruction enable |

## Verification
The assertions check, on every cycle, the properties that must hold whenever a trap is reported:
- the link write is withheld;
- the redirect points at the vector;
- the reported target is misaligned for the previous mode;
- the redirect that accompanies a trap goes to the vector.

They also check that no write ever goes to index 0 and that every non-trap redirect is even. Other behaviours can only be shown by the bench's sweeps, because they depend on exact values:
- the target arithmetic for each operation kind;
- the mode-dependent masking on trap return;
- the dropping of a clear request from an unaligned location;
- the reset value of the compressed bit.

// File: rtl/fat_pkg.sv
package fat_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_JAL    = 3'd1,
        OP_JALR   = 3'd2,
        OP_BRANCH = 3'd3,
        OP_CWR    = 3'd4,
        OP_TRET   = 3'd5
    } op_e;

    localparam int unsigned CAUSE_W        = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGNED = '0;
    localparam int unsigned INSN_BYTES     = 4;
endpackage

// File: rtl/fat_target.sv
module fat_target
    import fat_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  op_e             op_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] offset_i,
    input  logic            c_en_i,
    output logic [XLEN-1:0] tgt_o
);
    logic [XLEN-1:0] sum_rel;
    logic [XLEN-1:0] sum_ind;
    logic [XLEN-1:0] tret_mask;

    always_comb begin
        sum_rel   = pc_i + offset_i;
        sum_ind   = base_i + offset_i;
        tret_mask = c_en_i ? {{(XLEN-1){1'b1}}, 1'b0} : {{(XLEN-2){1'b1}}, 2'b00};
        unique case (op_i)
            OP_JAL, OP_BRANCH: tgt_o = sum_rel;
            OP_JALR:           tgt_o = {sum_ind[XLEN-1:1], 1'b0};
            OP_TRET:           tgt_o = base_i & tret_mask;
            default:           tgt_o = '0;
        endcase
    end
endmodule

// File: rtl/fat_align_chk.sv
module fat_align_chk
    import fat_pkg::*;
(
    input  op_e        op_i,
    input  logic       taken_i,
    input  logic [1:0] tgt_lo_i,
    input  logic       c_en_i,
    output logic       xfer_o,
    output logic       fault_o
);
    logic checked;

    always_comb begin
        checked = (op_i == OP_JAL) || (op_i == OP_JALR) ||
                  ((op_i == OP_BRANCH) && taken_i);
        xfer_o  = checked || (op_i == OP_TRET);
        fault_o = checked && (tgt_lo_i[0] || (!c_en_i && tgt_lo_i[1]));
    end
endmodule

// File: rtl/fat_cbit_ctl.sv
module fat_cbit_ctl
    import fat_pkg::*;
(
    input  logic       op_valid_i,
    input  op_e        op_i,
    input  logic       wr_val_i,
    input  logic [1:0] pc_lo_i,
    input  logic       c_q_i,
    output logic       c_d_o
);
    logic [1:0] next_lo;

    always_comb begin
        next_lo = pc_lo_i + 2'(INSN_BYTES);
        c_d_o   = c_q_i;
        if (op_valid_i && op_i == OP_CWR) begin
            if (wr_val_i)
                c_d_o = 1'b1;
            else if (!next_lo[1])
                c_d_o = 1'b0;
        end
    end
endmodule

// File: rtl/fetch_align_trap.sv
module fetch_align_trap
    import fat_pkg::*;
#(
    parameter int unsigned     XLEN = 32,
    parameter logic [XLEN-1:0] TVEC = 32'h0000_0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid_i,
    input  logic [2:0]          op_i,
    input  logic                taken_i,
    input  logic [XLEN-1:0]     base_i,
    input  logic [XLEN-1:0]     offset_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [4:0]          rd_i,
    input  logic                cwr_val_i,
    output logic                redir_valid_o,
    output logic [XLEN-1:0]     redir_pc_o,
    output logic                link_we_o,
    output logic [4:0]          link_rd_o,
    output logic [XLEN-1:0]     link_data_o,
    output logic                trap_valid_o,
    output logic [CAUSE_W-1:0]  trap_cause_o,
    output logic [XLEN-1:0]     trap_epc_o,
    output logic [XLEN-1:0]     trap_tval_o,
    output logic                c_en_o
);
    typedef struct packed {
        logic               redir_valid;
        logic [XLEN-1:0]    redir_pc;
        logic               link_we;
        logic [4:0]         link_rd;
        logic [XLEN-1:0]    link_data;
        logic               trap_valid;
        logic [CAUSE_W-1:0] trap_cause;
        logic [XLEN-1:0]    trap_epc;
        logic [XLEN-1:0]    trap_tval;
        logic               c_en;
    } state_t;

    state_t st_d, st_q;
    op_e    op;
    logic [XLEN-1:0] tgt;
    logic   xfer, fault, c_next;

    assign op = op_e'(op_i);

    fat_target #(.XLEN(XLEN)) u_target (
        .op_i     (op),
        .pc_i     (pc_i),
        .base_i   (base_i),
        .offset_i (offset_i),
        .c_en_i   (st_q.c_en),
        .tgt_o    (tgt)
    );

    fat_align_chk u_align (
        .op_i     (op),
        .taken_i  (taken_i),
        .tgt_lo_i (tgt[1:0]),
        .c_en_i   (st_q.c_en),
        .xfer_o   (xfer),
        .fault_o  (fault)
    );

    fat_cbit_ctl u_cbit (
        .op_valid_i (op_valid_i),
        .op_i       (op),
        .wr_val_i   (cwr_val_i),
        .pc_lo_i    (pc_i[1:0]),
        .c_q_i      (st_q.c_en),
        .c_d_o      (c_next)
    );

    always_comb begin
        logic trap;
        logic is_jump;
        trap    = op_valid_i && fault;
        is_jump = (op == OP_JAL) || (op == OP_JALR);

        st_d             = st_q;
        st_d.c_en        = c_next;
        st_d.redir_valid = op_valid_i && xfer;
        st_d.redir_pc    = trap ? TVEC : (op_valid_i && xfer ? tgt : '0);
        st_d.link_we     = op_valid_i && is_jump && !trap && (rd_i != 5'd0);
        st_d.link_rd     = rd_i;
        st_d.link_data   = pc_i + XLEN'(INSN_BYTES);
        st_d.trap_valid  = trap;
        st_d.trap_cause  = CAUSE_MISALIGNED;
        st_d.trap_epc    = trap ? pc_i : '0;
        st_d.trap_tval   = trap ? tgt : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.c_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign redir_valid_o = st_q.redir_valid;
    assign redir_pc_o    = st_q.redir_pc;
    assign link_we_o     = st_q.link_we;
    assign link_rd_o     = st_q.link_rd;
    assign link_data_o   = st_q.link_data;
    assign trap_valid_o  = st_q.trap_valid;
    assign trap_cause_o  = st_q.trap_cause;
    assign trap_epc_o    = st_q.trap_epc;
    assign trap_tval_o   = st_q.trap_tval;
    assign c_en_o        = st_q.c_en;
endmodule

// File: rtl/fat_checker.sv
module fat_checker #(
    parameter int unsigned     XLEN = 32,
    parameter logic [XLEN-1:0] TVEC = 32'h0000_0100
) (
    input logic            clk,
    input logic            rst_n,
    input logic            redir_valid_o,
    input logic [XLEN-1:0] redir_pc_o,
    input logic            link_we_o,
    input logic [4:0]      link_rd_o,
    input logic            trap_valid_o,
    input logic [XLEN-1:0] trap_tval_o,
    input logic            c_en_o
);
    // A trap suppresses the link write.
    assert_no_link_on_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_o |-> !link_we_o);

    // Index 0 is never written.
    assert_no_write_x0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> link_rd_o != 5'd0);

    // A trap redirects to the vector.
    assert_trap_to_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_o |-> (redir_valid_o && redir_pc_o == TVEC));

    // A trap target has bit 1 set only when the mode in force at issue was 4-byte alignment.
    assert_trap_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_o && trap_tval_o[1] && !trap_tval_o[0]) |-> !$past(c_en_o));

    // A target that redirects without a trap is even.
    assert_even_redirect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid_o && !trap_valid_o) |-> !redir_pc_o[0]);
endmodule

bind fetch_align_trap fat_checker #(.XLEN(XLEN), .TVEC(TVEC)) u_fat_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .redir_valid_o (redir_valid_o),
    .redir_pc_o    (redir_pc_o),
    .link_we_o     (link_we_o),
    .link_rd_o     (link_rd_o),
    .trap_valid_o  (trap_valid_o),
    .trap_tval_o   (trap_tval_o),
    .c_en_o        (c_en_o)
);

// File: tb/fetch_align_trap_bench.sv
`timescale 1ns/1ps
module fetch_align_trap_bench;
    localparam int unsigned XLEN = 32;
    localparam logic [31:0] TVEC = 32'h0000_0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid_i = 1'b0;
    logic [2:0] op_i = '0;
    logic taken_i = 1'b0;
    logic [31:0] base_i = '0, offset_i = '0, pc_i = '0;
    logic [4:0] rd_i = '0;
    logic cwr_val_i = 1'b0;
    logic redir_valid_o, link_we_o, trap_valid_o, c_en_o;
    logic [31:0] redir_pc_o, link_data_o, trap_epc_o, trap_tval_o;
    logic [4:0] link_rd_o;
    logic [3:0] trap_cause_o;

    int checks = 0;
    int errors = 0;
    bit model_c = 1'b1;

    always #4 clk = ~clk;

    fetch_align_trap #(.XLEN(XLEN), .TVEC(TVEC)) u_fetch_align_trap (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at negedge, registered at next posedge, sample at following negedge.
    task automatic issue(input logic [2:0] op, input logic tk, input logic [31:0] b,
                         input logic [31:0] off, input logic [31:0] pc,
                         input logic [4:0] rd, input logic cw);
        op_valid_i = 1'b1; op_i = op; taken_i = tk; base_i = b;
        offset_i = off; pc_i = pc; rd_i = rd; cwr_val_i = cw;
        @(posedge clk);
        @(negedge clk);
        op_valid_i = 1'b0;
    endtask

    task automatic set_c(input bit v);
        issue(3'd4, 1'b0, 0, 0, 32'h40, 5'd0, v);
        model_c = v;
        chk("R8", "c_en after write", {31'd0, c_en_o}, {31'd0, v});
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "c_en reset", {31'd0, c_en_o}, 32'd1);
        chk("R10", "valids reset", {29'd0, redir_valid_o, link_we_o, trap_valid_o}, 32'd0);

        // Sweep of transfers across both modes and low-bit patterns.
        for (int c = 0; c < 2; c++) begin
            set_c(c[0]);
            for (int k = 1; k <= 3; k++) begin
                for (int tk = 0; tk < 2; tk++) begin
                    for (int bl = 0; bl < 4; bl++) begin
                        for (int ol = 0; ol < 4; ol++) begin
                            for (int rsel = 0; rsel < 2; rsel++) begin
                                logic [31:0] pc, b, off, tgt;
                                logic [4:0] rd;
                                bit xfer, fault, jmp;
                                string rq;
                                pc  = 32'h1000 + 32'(c * 64 + k * 16);
                                b   = 32'h2000 + 32'(bl);
                                off = 32'h0000_0020 + 32'(ol);
                                rd  = rsel ? 5'd5 : 5'd0;
                                if (k == 2) tgt = (b + off) & ~32'h1;
                                else        tgt = pc + off;
                                jmp   = (k != 3);
                                xfer  = jmp || tk;
                                fault = xfer && (tgt[0] || (!model_c && tgt[1]));
                                rq = !xfer ? "R4" : fault ? (k == 2 ? "R1" : "R3") : (tgt[1] ? "R2" : "R1");
                                issue(3'(k), tk[0], b, off, pc, rd, 1'b0);
                                chk(rq, "trap_valid", {31'd0, trap_valid_o}, {31'd0, fault});
                                chk(rq, "redir_valid", {31'd0, redir_valid_o}, {31'd0, xfer});
                                if (xfer)
                                    chk(fault ? "R7" : rq, "redir_pc", redir_pc_o, fault ? TVEC : tgt);
                                chk("R5", "link_we", {31'd0, link_we_o},
                                    {31'd0, jmp && !fault && rd != 0});
                                if (jmp && !fault && rd != 0) begin
                                    chk("R5", "link_rd", {27'd0, link_rd_o}, {27'd0, rd});
                                    chk("R5", "link_data", link_data_o, pc + 4);
                                end
                                if (fault) begin
                                    chk("R6", "epc", trap_epc_o, pc);
                                    chk("R6", "tval", trap_tval_o, tgt);
                                    chk("R6", "cause", {28'd0, trap_cause_o}, 32'd0);
                                end
                                // R10: pulse lasts one cycle
                                @(negedge clk);
                                chk("R10", "trap one cycle", {31'd0, trap_valid_o}, 32'd0);
                            end
                        end
                    end
                end
            end
        end

        // Compressed-bit write: set always, clear dropped when pc+4 not 4-byte aligned.
        for (int start = 0; start < 2; start++) begin
            for (int pl = 0; pl < 4; pl += 2) begin
                for (int v = 0; v < 2; v++) begin
                    logic [31:0] pc;
                    bit exp_c;
                    set_c(start[0]);
                    pc = 32'h3000 + 32'(pl);
                    exp_c = v ? 1'b1 : (((pc + 4) & 32'h2) != 0 ? model_c : 1'b0);
                    issue(3'd4, 1'b0, 0, 0, pc, 5'd0, v[0]);
                    model_c = exp_c;
                    chk("R8", "cbit write", {31'd0, c_en_o}, {31'd0, exp_c});
                    chk("R8", "no redirect on write", {31'd0, redir_valid_o}, 32'd0);
                end
            end
        end

        // Trap return masking in both modes.
        for (int c = 0; c < 2; c++) begin
            set_c(c[0]);
            for (int bl = 0; bl < 4; bl++) begin
                logic [31:0] b, exp;
                b = 32'h4000 + 32'(bl);
                exp = model_c ? (b & ~32'h1) : (b & ~32'h3);
                issue(3'd5, 1'b0, b, 0, 32'h5000, 5'd1, 1'b0);
                chk("R9", "tret redir", redir_pc_o, exp);
                chk("R9", "tret valid/no trap", {30'd0, redir_valid_o, trap_valid_o}, 32'd2);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule